// File: doc/BRIEF.md
# Instrument Status Summary Hierarchy

This block keeps the status state of a remotely controlled instrument and reduces it to a service request line. It uses two levels of masked summaries. The first level has two sticky event registers: an 8-bit event status register and a 16-bit internal state change register. Each is reduced through its own enable mask to one summary bit of an 8-bit status byte. At the second level, the status byte is reduced twice, each time through its own mask. The service request mask gives the master summary bit, which drives the service request output. The parallel poll mask gives the "ist" output.

The command parser, the execution logic and the parameter coercion logic report through single-cycle event pulses. The output queue reports through a level signal that is high while the queue is not empty. A simple register port lets software load the four masks, read every register and read-and-clear the two event registers. A clear-status pulse resets the event state and leaves the masks as they are.

Top module: `stat_report_top`

## Requirements
- R1: After reset the four masks, both event registers and the value-adapted bit are zero, the status byte reads 0 while the queue is empty, and `srq` and `ist` are low.
- R2: An event pulse on `esr_set` or `inr_set` ORs into the matching event register bit. The bit stays set until a read or a clear-status removes it.
- R3: A read of address 1 (event status) or address 2 (internal change) returns the current value in the same cycle and clears the register at the next edge. An event pulse in that same cycle is kept in the register.
- R4: A pulse on `cmd_err_nz` sets bit 5 of the event status register.
- R5: Status byte bit 5 is the OR of (event status AND event enable). Bit 0 is the OR of (internal change AND internal enable). Both follow one cycle after the event or the mask write.
- R6: Status byte bit 4 equals `outq_nonempty` in the same cycle.
- R7: Status byte bit 2 is set by a `val_adapt` pulse. It stays set when the status byte is read and is cleared only by clear-status.
- R8: Status byte bit 6 and `srq` are the OR of (status byte bits other than 6 AND the service request mask). Bit 6 of that mask has no effect.
- R9: `ist` is the OR of (status byte bits other than 6 AND the parallel poll mask). It does not depend on the service request mask.
- R10: A `clr_status` pulse zeroes both event registers and the value-adapted bit and leaves all masks unchanged. An internal change event in the same cycle is kept.
- R11: The address map is 0 status byte, 1 event status, 2 internal change, 3 event enable, 4 internal enable, 5 service request mask, 6 parallel poll mask. Writes to addresses 0 to 2 are ignored, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esr_set | input | 8 | Event pulses into the event status register |
| inr_set | input | 16 | Event pulses into the internal state change register |
| cmd_err_nz | input | 1 | Pulse: the command error code became nonzero |
| val_adapt | input | 1 | Pulse: a parameter was coerced to a legal value |
| outq_nonempty | input | 1 | Level: the output queue holds data |
| clr_status | input | 1 | Pulse: clear-status command |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears event registers) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of the strobe |
| srq | output | 1 | Service request (master summary) |
| ist | output | 1 | Parallel poll status bit |

## Verification
A lost or stuck bit in an event register shows up at the ports in two ways. The event register itself returns the wrong value on its next read. The status byte and `srq` show a wrong summary one cycle after the event, provided the matching masks are enabled. With all masks at zero, a wrong internal bit stays hidden until software reads the register. For that reason the bench reads every register directly, and also checks the summaries once the masks are open. A mask that is corrupted by clear-status, or a mask bit 6 that feeds its own reduction, appears at `srq` or `ist` in the cycle after the cause.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STB_W  = 8;
  localparam int ADDR_W = 3;

  // status byte positions (decoded by the host, so they are fixed)
  localparam int INB_POS = 0;
  localparam int VAB_POS = 2;
  localparam int MAV_POS = 4;
  localparam int ESB_POS = 5;
  localparam int MSS_POS = 6;
  // event status bit set by a nonzero command error code
  localparam int CME_POS = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_STB = 3'd0,
    A_ESR = 3'd1,
    A_INR = 3'd2,
    A_ESE = 3'd3,
    A_INE = 3'd4,
    A_SRE = 3'd5,
    A_PRE = 3'd6
  } reg_addr_e;

  // masked AND-then-OR reduction used at both summary levels
  function automatic logic any_enabled(input logic [31:0] status, input logic [31:0] enable);
    return |(status & enable);
  endfunction
endpackage

// File: rtl/stat_sticky_reg.sv
module stat_sticky_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         rd_clr,
  input  logic         clr_all,
  output logic [W-1:0] q
);
  logic         wipe;
  logic [W-1:0] kept;

  assign wipe = rd_clr | clr_all;
  assign kept = wipe ? '0 : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= kept | set;
  end

  // R2: bits stay set while nothing clears them
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !clr_all) |=> ((q & $past(q)) == $past(q)));
  // R3: an event in any cycle, including a clearing one, is kept
  p_set_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
  // R3 / R10: a clear with no event leaves the register empty
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_clr || clr_all) && set == '0) |=> (q == '0));
endmodule

// File: rtl/stat_mask_reg.sv
module stat_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/stat_byte_logic.sv
module stat_byte_logic
  import stat_pkg::*;
#(
  parameter int ESR_W = 8,
  parameter int INR_W = 16
) (
  input  logic [ESR_W-1:0] esr,
  input  logic [ESR_W-1:0] ese,
  input  logic [INR_W-1:0] inr,
  input  logic [INR_W-1:0] ine,
  input  logic             vab,
  input  logic             mav,
  input  logic [STB_W-1:0] sre,
  input  logic [STB_W-1:0] pre,
  output logic             esb,
  output logic             inb,
  output logic [STB_W-1:0] stb,
  output logic             mss,
  output logic             ist
);
  logic [STB_W-1:0] stb_base;

  assign esb = any_enabled(32'(esr), 32'(ese));
  assign inb = any_enabled(32'(inr), 32'(ine));

  always_comb begin
    stb_base          = '0;
    stb_base[INB_POS] = inb;
    stb_base[VAB_POS] = vab;
    stb_base[MAV_POS] = mav;
    stb_base[ESB_POS] = esb;
  end

  // bit MSS_POS of stb_base is zero, so the mask cannot feed back on itself
  assign mss = any_enabled(32'(stb_base), 32'(sre));
  assign ist = any_enabled(32'(stb_base), 32'(pre));

  always_comb begin
    stb          = stb_base;
    stb[MSS_POS] = mss;
  end
endmodule

// File: rtl/stat_report_top.sv
module stat_report_top
  import stat_pkg::*;
#(
  parameter int ESR_W = 8,
  parameter int INR_W = 16,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ESR_W-1:0]     esr_set,
  input  logic [INR_W-1:0]     inr_set,
  input  logic                 cmd_err_nz,
  input  logic                 val_adapt,
  input  logic                 outq_nonempty,
  input  logic                 clr_status,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 srq,
  output logic                 ist
);
  // named internal events
  logic [ESR_W-1:0] esr_evt, esr_q, ese_q;
  logic [INR_W-1:0] inr_q, ine_q;
  logic [STB_W-1:0] sre_q, pre_q, stb;
  logic             vab_q, esb, inb, mss, ist_w;
  logic             rd_esr, rd_inr;
  logic             wr_ese, wr_ine, wr_sre, wr_pre;

  always_comb begin
    esr_evt          = esr_set;
    esr_evt[CME_POS] = esr_set[CME_POS] | cmd_err_nz;
  end

  assign rd_esr = reg_rd && (reg_addr == A_ESR);
  assign rd_inr = reg_rd && (reg_addr == A_INR);
  assign wr_ese = reg_wr && (reg_addr == A_ESE);
  assign wr_ine = reg_wr && (reg_addr == A_INE);
  assign wr_sre = reg_wr && (reg_addr == A_SRE);
  assign wr_pre = reg_wr && (reg_addr == A_PRE);

  stat_sticky_reg #(.W(ESR_W)) u_esr (
    .clk(clk), .rst_n(rst_n), .set(esr_evt), .rd_clr(rd_esr),
    .clr_all(clr_status), .q(esr_q));

  stat_sticky_reg #(.W(INR_W)) u_inr (
    .clk(clk), .rst_n(rst_n), .set(inr_set), .rd_clr(rd_inr),
    .clr_all(clr_status), .q(inr_q));

  stat_mask_reg #(.W(ESR_W)) u_ese (
    .clk(clk), .rst_n(rst_n), .we(wr_ese), .wdata(reg_wdata[ESR_W-1:0]), .q(ese_q));
  stat_mask_reg #(.W(INR_W)) u_ine (
    .clk(clk), .rst_n(rst_n), .we(wr_ine), .wdata(reg_wdata[INR_W-1:0]), .q(ine_q));
  stat_mask_reg #(.W(STB_W)) u_sre (
    .clk(clk), .rst_n(rst_n), .we(wr_sre), .wdata(reg_wdata[STB_W-1:0]), .q(sre_q));
  stat_mask_reg #(.W(STB_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .we(wr_pre), .wdata(reg_wdata[STB_W-1:0]), .q(pre_q));

  // value-adapted flag: sticky, only clear-status removes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vab_q <= 1'b0;
    else if (val_adapt)  vab_q <= 1'b1;
    else if (clr_status) vab_q <= 1'b0;
  end

  stat_byte_logic #(.ESR_W(ESR_W), .INR_W(INR_W)) u_stb (
    .esr(esr_q), .ese(ese_q), .inr(inr_q), .ine(ine_q),
    .vab(vab_q), .mav(outq_nonempty), .sre(sre_q), .pre(pre_q),
    .esb(esb), .inb(inb), .stb(stb), .mss(mss), .ist(ist_w));

  assign srq = mss;
  assign ist = ist_w;

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_STB:   reg_rdata = DW'(stb);
      A_ESR:   reg_rdata = DW'(esr_q);
      A_INR:   reg_rdata = DW'(inr_q);
      A_ESE:   reg_rdata = DW'(ese_q);
      A_INE:   reg_rdata = DW'(ine_q);
      A_SRE:   reg_rdata = DW'(sre_q);
      A_PRE:   reg_rdata = DW'(pre_q);
      default: reg_rdata = '0;
    endcase
  end

  // R8: a request needs some service request mask bit
  p_srq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> (sre_q != '0));
  // R9: ist needs some parallel poll mask bit
  p_ist_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ist |-> (pre_q != '0));
  // R10: clear-status leaves every mask untouched
  p_masks_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !reg_wr) |=> ($stable(ese_q) && $stable(ine_q) && $stable(sre_q) && $stable(pre_q)));
  // R7: the value-adapted flag holds until clear-status
  p_vab_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vab_q && !clr_status) |=> vab_q);
  // R11: a write to the event status address changes nothing
  p_esr_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ESR && !reg_rd && !clr_status && esr_evt == '0)
      |=> (esr_q == $past(esr_q)));
  // R5: the event summary appears one cycle after an enabled event
  p_esb_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((esr_evt & ese_q) != '0 && !wr_ese) |=> esb);
endmodule

// File: tb/sim_stat_report_top.sv
module sim_stat_report_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  esr_set = '0;
  logic [15:0] inr_set = '0;
  logic        cmd_err_nz = 1'b0, val_adapt = 1'b0, outq_nonempty = 1'b0, clr_status = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        srq, ist;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  stat_report_top u0 (
    .clk(clk), .rst_n(rst_n), .esr_set(esr_set), .inr_set(inr_set),
    .cmd_err_nz(cmd_err_nz), .val_adapt(val_adapt), .outq_nonempty(outq_nonempty),
    .clr_status(clr_status), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .srq(srq), .ist(ist));

  // monitor: pops the expected read value for each strobed read
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read actual %h expected none", reg_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s read addr %0d actual %h expected %h", t, reg_addr, reg_rdata, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    esr_set = '0; inr_set = '0; cmd_err_nz = 0; val_adapt = 0; clr_status = 0;
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic evt(input logic [7:0] e, input logic [15:0] i, input logic ce,
                     input logic va, input logic cl);
    esr_set = e; inr_set = i; cmd_err_nz = ce; val_adapt = va; clr_status = cl;
    step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  // driver: queues the expectation, then strobes the read (with optional same-cycle event)
  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t,
                    input logic [7:0] se = 8'h00);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_rd = 1; reg_addr = a; esr_set = se;
    step();
  endtask

  task automatic chk_out(input logic es, input logic ei, input string t);
    @(negedge clk);
    checks++;
    if (srq !== es || ist !== ei) begin
      errors++;
      $display("FAIL %s srq/ist actual %b%b expected %b%b", t, srq, ist, es, ei);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    rd(0, 16'h0000, "R1 stb");
    rd(3, 16'h0000, "R1 ese");
    rd(4, 16'h0000, "R1 ine");
    rd(5, 16'h0000, "R1 sre");
    rd(6, 16'h0000, "R1 pre");
    rd(1, 16'h0000, "R1 esr");
    chk_out(0, 0, "R1");
    // R2, R3: sticky and read-clear
    evt(8'h05, 0, 0, 0, 0);
    rd(1, 16'h0005, "R2 esr sticky");
    rd(1, 16'h0000, "R3 cleared by read");
    // R4, R5: command error, masked summary
    evt(0, 0, 1, 0, 0);
    rd(0, 16'h0000, "R5 esb masked off");
    wr(3, 16'h0020);
    rd(0, 16'h0020, "R4 esb via bit5");
    chk_out(0, 0, "R8 no sre");
    // R8: mask bit 6 has no effect, then bit 5 gives the request
    wr(5, 16'h0040);
    chk_out(0, 0, "R8 sre bit6 ignored");
    wr(5, 16'h0020);
    chk_out(1, 0, "R8 srq / R9 no pre");
    rd(0, 16'h0060, "R8 mss in stb");
    // R3: event in the read cycle is kept
    rd(1, 16'h0020, "R3 read with event", 8'h80);
    chk_out(0, 0, "R3 esb gone after read");
    rd(1, 16'h0080, "R3 event kept");
    // R5, R9: internal change path
    wr(4, 16'h0100);
    evt(0, 16'h0100, 0, 0, 0);
    rd(0, 16'h0001, "R5 inb");
    wr(6, 16'h0001);
    chk_out(0, 1, "R9 ist");
    // R6: message available same cycle
    outq_nonempty = 1;
    rd(0, 16'h0011, "R6 mav");
    // R7: value adapted
    evt(0, 0, 0, 1, 0);
    rd(0, 16'h0015, "R7 vab set");
    rd(0, 16'h0015, "R7 vab sticky");
    evt(0, 0, 1, 0, 0);
    chk_out(1, 1, "R8 srq via esb");
    // R10: clear-status with same-cycle internal event
    evt(0, 16'h0002, 0, 0, 1);
    rd(0, 16'h0010, "R10 stb after cls");
    chk_out(0, 0, "R10 summaries cleared");
    rd(3, 16'h0020, "R10 ese kept");
    rd(5, 16'h0020, "R10 sre kept");
    rd(4, 16'h0100, "R10 ine kept");
    rd(6, 16'h0001, "R10 pre kept");
    rd(2, 16'h0002, "R10 event kept");
    // R11: read-only and unused addresses
    wr(1, 16'h00FF);
    wr(0, 16'h00FF);
    rd(1, 16'h0000, "R11 esr not writable");
    rd(0, 16'h0010, "R11 stb not writable");
    rd(7, 16'h0000, "R11 unused addr");
    // R6, R8: request from message available
    wr(5, 16'h0010);
    chk_out(1, 0, "R8 srq via mav");
    outq_nonempty = 0;
    chk_out(0, 0, "R6 mav drops");
    step();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 reads pending actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule